// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the program counter (PC) and next program counter (nPC) of an integer core whose control transfers are delayed by one instruction. Each time the execute stage retires an instruction, it reports whether that instruction was a taken control transfer, its computed target, and whether its annul bit was set. A taken transfer never replaces the PC directly. The instruction at the old nPC runs first as the delay slot, and the target reaches the PC only after that slot has retired. A conditional branch that is not taken but has its annul bit set marks its delay slot as squashed. The squashed instruction still moves PC and nPC forward, but none of its control-transfer information is used.

The block samples interrupts at instruction boundaries. An interrupt is taken only when all of the following hold:
- an instruction is offered for retirement;
- traps are enabled;
- the request level is strictly above the current processor interrupt level.

The offered instruction is then dropped and is not executed. The block raises a trap request carrying the following values, all of which stay stable until a vector address arrives:
- a trap type equal to 0x10 plus the request level;
- the PC of the dropped instruction;
- the nPC of the dropped instruction.

Trap entry clears any pending squash. The block then waits for a vector address. Once the vector is accepted, fetching resumes at the vector address, followed by the vector address plus 4.

Two handshakes carry data, and both follow valid/ready rules. The retire port completes a transfer on a cycle where `retire_valid` and `retire_ready` are both high. `retire_ready` is low only while a trap is waiting for its vector, and `retire_valid` is ignored during that time. The vector port uses `trap_req` as its ready signal. `vec_addr` is taken on the first cycle where `vec_valid` and `trap_req` are both high, and `vec_valid` is ignored at all other times. On a retire that enters a trap, the offered instruction is consumed but not executed; it is fetched again after the handler returns.

Top module: `dbr_pc_sequencer`

## Requirements
- R1: After reset, fetch_addr is 0, nPC is 4, squash_slot and trap_req are 0, and retire_ready is 1.
- R2: A retire with no trap, no squash and cti_taken=0 sets fetch_addr to the old nPC and nPC to the old nPC plus 4.
- R3: A retire with cti_taken=1 sets fetch_addr to the old nPC (the delay slot) and nPC to cti_target. The next retire then sets fetch_addr to that target.
- R4: A retire with cti_taken=0 and cti_annul=1 raises squash_slot for the following instruction, and fetching still advances sequentially.
- R5: A retire with cti_taken=1 and cti_annul=1 does not squash its delay slot (squash_slot stays 0).
- R6: When a retire is accepted while squash_slot=1, its cti_taken, cti_annul and cti_target are ignored. PC and nPC advance sequentially and squash_slot returns to 0.
- R7: A trap is entered only when retire_valid=1, trap_en=1 and irq_level > cur_pil (unsigned, 4 bits). As a result, level 0, a level equal to cur_pil, or trap_en=0 never causes a trap.
- R8: On trap entry, trap_req rises on the next cycle with trap_type = 0x10 + irq_level (8 bits). At the same time, trap_pc and trap_npc take the PC and nPC of the instruction at the boundary.
- R9: Trap entry clears a pending squash (squash_slot is 0 while the trap waits).
- R10: While trap_req=1, retire_ready is 0, retires are ignored and fetch_addr holds. When vec_valid=1, the next cycle shows fetch_addr = vec_addr and trap_req = 0, and the following retire gives vec_addr plus 4.
- R11: On a cycle with retire_valid=0 and no trap waiting, fetch_addr, nPC and squash_slot keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_valid | input | 1 | Execute stage offers the instruction at fetch_addr for retirement |
| retire_ready | output | 1 | Sequencer can accept a retire (low while a trap awaits its vector) |
| cti_taken | input | 1 | Retiring instruction is a taken control transfer |
| cti_annul | input | 1 | Annul bit of the retiring conditional branch |
| cti_target | input | AW | Target address of a taken control transfer |
| irq_level | input | LVL_W | Pending interrupt request level, 0 means none |
| cur_pil | input | LVL_W | Current processor interrupt level |
| trap_en | input | 1 | Traps enabled |
| vec_valid | input | 1 | Trap vector address offered |
| vec_addr | input | AW | Trap vector address |
| fetch_addr | output | AW | Current PC, the address to fetch |
| squash_slot | output | 1 | Instruction at fetch_addr is annulled |
| trap_req | output | 1 | Trap entered, waiting for a vector (ready for the vector port) |
| trap_type | output | TT_W | Trap type of the entered interrupt |
| trap_pc | output | AW | PC saved at trap entry |
| trap_npc | output | AW | nPC saved at trap entry |

## Verification
The bound checker compares every accepted retire against the previous nPC and target. On every cycle it checks:
- sequential advance, delayed transfer, annul and ignore-while-squashed;
- the interrupt gating and the trap type;
- the saved PC and nPC;
- the clearing of the squash at trap entry;
- the hold and vector behaviour while waiting.

Only the directed scenarios show whole sequences. These are a taken branch whose target appears one retire later, a squash that is followed by the offered but ignored transfer, and a trap taken inside a delay slot that saves the branch target as nPC. The scenarios also show that the retires offered while waiting leave no trace after the vector is accepted.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // What the PC/nPC pair does on the coming edge.
  typedef enum logic [2:0] {
    STEP_HOLD,
    STEP_SEQ,
    STEP_BRANCH,
    STEP_TRAP,
    STEP_VECTOR
  } step_e;

endpackage

// File: rtl/pcseq_irq_gate.sv
module pcseq_irq_gate #(
  parameter int LVL_W   = 4,
  parameter int TT_W    = 8,
  parameter int TT_BASE = 16
) (
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] cur_pil,
  input  logic             trap_en,
  output logic             irq_pending,
  output logic [TT_W-1:0]  irq_type
);

  // A zero level can never exceed the interrupt level, so it means no request.
  always_comb begin
    irq_pending = trap_en && (irq_level > cur_pil);
    irq_type    = TT_W'(TT_BASE) + TT_W'(irq_level);
  end

endmodule

// File: rtl/pcseq_step_ctl.sv
module pcseq_step_ctl
  import pcseq_pkg::*;
(
  input  logic  retire_valid,
  input  logic  waiting,
  input  logic  squash_q,
  input  logic  irq_pending,
  input  logic  cti_taken,
  input  logic  cti_annul,
  input  logic  vec_valid,
  output logic  retire_ready,
  output step_e step,
  output logic  annul_d
);

  always_comb begin
    retire_ready = !waiting;
    step         = STEP_HOLD;
    annul_d      = squash_q;
    if (waiting) begin
      if (vec_valid) begin
        step    = STEP_VECTOR;
        annul_d = 1'b0;
      end
    end else if (retire_valid) begin
      if (irq_pending) begin
        // Trap entry drops the offered instruction and any pending squash.
        step    = STEP_TRAP;
        annul_d = 1'b0;
      end else if (squash_q) begin
        // Annulled slot: advance, but use none of its transfer fields.
        step    = STEP_SEQ;
        annul_d = 1'b0;
      end else if (cti_taken) begin
        step    = STEP_BRANCH;
        annul_d = 1'b0;
      end else begin
        step    = STEP_SEQ;
        annul_d = cti_annul;
      end
    end
  end

endmodule

// File: rtl/pcseq_pc_regs.sv
module pcseq_pc_regs
  import pcseq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] RESET_PC   = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  logic [AW-1:0] cti_target,
  input  logic [AW-1:0] vec_addr,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] npc_q
);

  localparam logic [AW-1:0] STRIDE = AW'(INSN_BYTES);
  localparam logic [AW-1:0] PC0    = AW'(RESET_PC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= PC0;
      npc_q <= PC0 + STRIDE;
    end else begin
      case (step)
        STEP_SEQ: begin
          pc_q  <= npc_q;
          npc_q <= npc_q + STRIDE;
        end
        STEP_BRANCH: begin
          // Delay slot comes from nPC; the target waits one retire in nPC.
          pc_q  <= npc_q;
          npc_q <= cti_target;
        end
        STEP_VECTOR: begin
          pc_q  <= vec_addr;
          npc_q <= vec_addr + STRIDE;
        end
        default: begin
          pc_q  <= pc_q;
          npc_q <= npc_q;
        end
      endcase
    end
  end

endmodule

// File: rtl/pcseq_trap_hold.sv
module pcseq_trap_hold
  import pcseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int TT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  step_e           step,
  input  logic [AW-1:0]   pc_q,
  input  logic [AW-1:0]   npc_q,
  input  logic [TT_W-1:0] irq_type,
  output logic            waiting,
  output logic [TT_W-1:0] tt_q,
  output logic [AW-1:0]   tpc_q,
  output logic [AW-1:0]   tnpc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      tt_q    <= '0;
      tpc_q   <= '0;
      tnpc_q  <= '0;
    end else if (step == STEP_TRAP) begin
      waiting <= 1'b1;
      tt_q    <= irq_type;
      tpc_q   <= pc_q;
      tnpc_q  <= npc_q;
    end else if (step == STEP_VECTOR) begin
      waiting <= 1'b0;
    end
  end

endmodule

// File: rtl/dbr_pc_sequencer.sv
module dbr_pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          LVL_W      = 4,
  parameter int          TT_W       = 8,
  parameter int          TT_BASE    = 16,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] RESET_PC   = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_valid,
  output logic             retire_ready,
  input  logic             cti_taken,
  input  logic             cti_annul,
  input  logic [AW-1:0]    cti_target,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] cur_pil,
  input  logic             trap_en,
  input  logic             vec_valid,
  input  logic [AW-1:0]    vec_addr,
  output logic [AW-1:0]    fetch_addr,
  output logic             squash_slot,
  output logic             trap_req,
  output logic [TT_W-1:0]  trap_type,
  output logic [AW-1:0]    trap_pc,
  output logic [AW-1:0]    trap_npc
);

  step_e           step;
  logic            irq_pending;
  logic [TT_W-1:0] irq_type;
  logic            waiting;
  logic            squash_q;
  logic            annul_d;
  logic [AW-1:0]   pc_q;
  logic [AW-1:0]   npc_q;

  pcseq_irq_gate #(.LVL_W(LVL_W), .TT_W(TT_W), .TT_BASE(TT_BASE)) u_irq (
    .irq_level   (irq_level),
    .cur_pil     (cur_pil),
    .trap_en     (trap_en),
    .irq_pending (irq_pending),
    .irq_type    (irq_type)
  );

  pcseq_step_ctl u_ctl (
    .retire_valid (retire_valid),
    .waiting      (waiting),
    .squash_q     (squash_q),
    .irq_pending  (irq_pending),
    .cti_taken    (cti_taken),
    .cti_annul    (cti_annul),
    .vec_valid    (vec_valid),
    .retire_ready (retire_ready),
    .step         (step),
    .annul_d      (annul_d)
  );

  pcseq_pc_regs #(.AW(AW), .INSN_BYTES(INSN_BYTES), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .cti_target (cti_target),
    .vec_addr   (vec_addr),
    .pc_q       (pc_q),
    .npc_q      (npc_q)
  );

  pcseq_trap_hold #(.AW(AW), .TT_W(TT_W)) u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .pc_q     (pc_q),
    .npc_q    (npc_q),
    .irq_type (irq_type),
    .waiting  (waiting),
    .tt_q     (trap_type),
    .tpc_q    (trap_pc),
    .tnpc_q   (trap_npc)
  );

  // Squash flag for the instruction currently at the PC.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) squash_q <= 1'b0;
    else        squash_q <= annul_d;
  end

  assign fetch_addr  = pc_q;
  assign squash_slot = squash_q;
  assign trap_req    = waiting;

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int AW         = 32,
  parameter int LVL_W      = 4,
  parameter int TT_W       = 8,
  parameter int TT_BASE    = 16,
  parameter int INSN_BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire_valid,
  input logic             retire_ready,
  input logic             cti_taken,
  input logic             cti_annul,
  input logic [AW-1:0]    cti_target,
  input logic [LVL_W-1:0] irq_level,
  input logic [LVL_W-1:0] cur_pil,
  input logic             trap_en,
  input logic             vec_valid,
  input logic [AW-1:0]    vec_addr,
  input logic [AW-1:0]    fetch_addr,
  input logic             squash_slot,
  input logic             trap_req,
  input logic [TT_W-1:0]  trap_type,
  input logic [AW-1:0]    trap_pc,
  input logic [AW-1:0]    trap_npc,
  input logic [AW-1:0]    npc_q
);

  localparam logic [AW-1:0] STRIDE = AW'(INSN_BYTES);

  logic acc;
  logic irq_ok;
  assign acc    = retire_valid && retire_ready;
  assign irq_ok = trap_en && (irq_level > cur_pil);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_valid && !trap_req |=> $stable(fetch_addr) && $stable(npc_q) && $stable(squash_slot) && !trap_req);

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !irq_ok && !squash_slot && !cti_taken |=> fetch_addr == $past(npc_q) && npc_q == $past(npc_q) + STRIDE);

  p_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !irq_ok && !squash_slot && cti_taken |=> fetch_addr == $past(npc_q) && npc_q == $past(cti_target));

  p_annul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !irq_ok && !squash_slot && !cti_taken && cti_annul |=> squash_slot);

  p_taken_annul_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !irq_ok && !squash_slot && cti_taken && cti_annul |=> !squash_slot);

  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !irq_ok && squash_slot |=> !squash_slot && fetch_addr == $past(npc_q) && npc_q == $past(npc_q) + STRIDE);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(irq_ok && retire_valid));

  p_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> trap_type == TT_W'(TT_BASE) + TT_W'($past(irq_level))
                        && trap_pc == $past(fetch_addr) && trap_npc == $past(npc_q));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> !squash_slot);

  p_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !vec_valid |=> trap_req && $stable(fetch_addr) && $stable(trap_pc));

  p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && vec_valid |=> !trap_req && fetch_addr == $past(vec_addr) && npc_q == $past(vec_addr) + STRIDE);

endmodule

bind dbr_pc_sequencer pcseq_checker #(
  .AW(AW), .LVL_W(LVL_W), .TT_W(TT_W), .TT_BASE(TT_BASE), .INSN_BYTES(INSN_BYTES)
) u_pcseq_chk (
  .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_ready(retire_ready),
  .cti_taken(cti_taken), .cti_annul(cti_annul), .cti_target(cti_target),
  .irq_level(irq_level), .cur_pil(cur_pil), .trap_en(trap_en),
  .vec_valid(vec_valid), .vec_addr(vec_addr), .fetch_addr(fetch_addr),
  .squash_slot(squash_slot), .trap_req(trap_req), .trap_type(trap_type),
  .trap_pc(trap_pc), .trap_npc(trap_npc), .npc_q(npc_q)
);

// File: tb/tb_dbr_pc_sequencer.sv
module tb_dbr_pc_sequencer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_valid = 1'b0;
  logic        retire_ready;
  logic        cti_taken = 1'b0;
  logic        cti_annul = 1'b0;
  logic [31:0] cti_target = '0;
  logic [3:0]  irq_level = '0;
  logic [3:0]  cur_pil = '0;
  logic        trap_en = 1'b0;
  logic        vec_valid = 1'b0;
  logic [31:0] vec_addr = '0;
  logic [31:0] fetch_addr;
  logic        squash_slot;
  logic        trap_req;
  logic [7:0]  trap_type;
  logic [31:0] trap_pc;
  logic [31:0] trap_npc;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbr_pc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_ready(retire_ready),
    .cti_taken(cti_taken), .cti_annul(cti_annul), .cti_target(cti_target),
    .irq_level(irq_level), .cur_pil(cur_pil), .trap_en(trap_en),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .fetch_addr(fetch_addr),
    .squash_slot(squash_slot), .trap_req(trap_req), .trap_type(trap_type),
    .trap_pc(trap_pc), .trap_npc(trap_npc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One retire offered for one cycle; results sampled just after the edge.
  task automatic retire(input logic tk, input logic an, input logic [31:0] tgt);
    @(negedge clk);
    retire_valid = 1'b1;
    cti_taken    = tk;
    cti_annul    = an;
    cti_target   = tgt;
    @(posedge clk);
    #1;
    retire_valid = 1'b0;
    cti_taken    = 1'b0;
    cti_annul    = 1'b0;
    cti_target   = '0;
  endtask

  task automatic set_irq(input logic [3:0] lvl, input logic [3:0] pil, input logic en);
    @(negedge clk);
    irq_level = lvl;
    cur_pil   = pil;
    trap_en   = en;
  endtask

  task automatic give_vector(input logic [31:0] va);
    @(negedge clk);
    vec_valid = 1'b1;
    vec_addr  = va;
    @(posedge clk);
    #1;
    vec_valid = 1'b0;
    vec_addr  = '0;
  endtask

  task automatic t_reset;
    chk("R1", "fetch_addr", fetch_addr, 32'h0);
    chk("R1", "squash_slot", {31'b0, squash_slot}, 32'h0);
    chk("R1", "trap_req", {31'b0, trap_req}, 32'h0);
    chk("R1", "retire_ready", {31'b0, retire_ready}, 32'h1);
    retire(1'b0, 1'b0, '0);
    chk("R1", "first step from reset nPC", fetch_addr, 32'h4);
  endtask

  task automatic t_sequential;
    retire(1'b0, 1'b0, '0);
    chk("R2", "seq 1", fetch_addr, 32'h8);
    retire(1'b0, 1'b0, 32'h55);
    chk("R2", "seq 2 ignores target", fetch_addr, 32'hC);
    repeat (3) @(negedge clk);
    chk("R11", "idle hold", fetch_addr, 32'hC);
    chk("R11", "idle squash", {31'b0, squash_slot}, 32'h0);
  endtask

  task automatic t_taken;
    retire(1'b1, 1'b0, 32'h100);
    chk("R3", "delay slot fetched", fetch_addr, 32'h10);
    retire(1'b0, 1'b0, '0);
    chk("R3", "target after slot", fetch_addr, 32'h100);
    retire(1'b0, 1'b0, '0);
    chk("R3", "after target", fetch_addr, 32'h104);
  endtask

  task automatic t_annul;
    retire(1'b0, 1'b1, '0);
    chk("R4", "slot address", fetch_addr, 32'h108);
    chk("R4", "slot squashed", {31'b0, squash_slot}, 32'h1);
    retire(1'b1, 1'b1, 32'h200);
    chk("R6", "squashed transfer ignored", fetch_addr, 32'h10C);
    chk("R6", "squash cleared", {31'b0, squash_slot}, 32'h0);
    retire(1'b0, 1'b0, '0);
    chk("R6", "no hidden target", fetch_addr, 32'h110);
  endtask

  task automatic t_taken_annul;
    retire(1'b1, 1'b1, 32'h300);
    chk("R5", "slot address", fetch_addr, 32'h114);
    chk("R5", "slot not squashed", {31'b0, squash_slot}, 32'h0);
    retire(1'b0, 1'b0, '0);
    chk("R5", "target reached", fetch_addr, 32'h300);
  endtask

  task automatic t_irq_blocked;
    set_irq(4'd5, 4'd5, 1'b1);
    retire(1'b0, 1'b0, '0);
    chk("R7", "equal level no trap", {31'b0, trap_req}, 32'h0);
    chk("R7", "equal level advance", fetch_addr, 32'h304);
    set_irq(4'd7, 4'd3, 1'b0);
    retire(1'b0, 1'b0, '0);
    chk("R7", "traps disabled no trap", {31'b0, trap_req}, 32'h0);
    chk("R7", "disabled advance", fetch_addr, 32'h308);
    set_irq(4'd0, 4'd0, 1'b1);
    retire(1'b0, 1'b0, '0);
    chk("R7", "level zero no trap", {31'b0, trap_req}, 32'h0);
    chk("R7", "level zero advance", fetch_addr, 32'h30C);
    set_irq(4'd9, 4'd2, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7", "no retire no trap", {31'b0, trap_req}, 32'h0);
    set_irq(4'd0, 4'd0, 1'b0);
  endtask

  task automatic t_irq_in_slot;
    retire(1'b1, 1'b0, 32'h400);
    chk("R3", "slot before trap", fetch_addr, 32'h310);
    set_irq(4'd9, 4'd2, 1'b1);
    retire(1'b0, 1'b0, '0);
    set_irq(4'd0, 4'd0, 1'b0);
    chk("R8", "trap_req", {31'b0, trap_req}, 32'h1);
    chk("R8", "trap_type", {24'b0, trap_type}, 32'h19);
    chk("R8", "trap_pc", trap_pc, 32'h310);
    chk("R8", "trap_npc holds target", trap_npc, 32'h400);
    chk("R10", "retire_ready low", {31'b0, retire_ready}, 32'h0);
    retire(1'b1, 1'b0, 32'h900);
    chk("R10", "retire ignored", fetch_addr, 32'h310);
    chk("R10", "still waiting", {31'b0, trap_req}, 32'h1);
    give_vector(32'h800);
    chk("R10", "vector fetch", fetch_addr, 32'h800);
    chk("R10", "trap_req dropped", {31'b0, trap_req}, 32'h0);
    retire(1'b0, 1'b0, '0);
    chk("R10", "vector plus 4", fetch_addr, 32'h804);
  endtask

  task automatic t_irq_clears_annul;
    retire(1'b0, 1'b1, '0);
    chk("R4", "squash before trap", {31'b0, squash_slot}, 32'h1);
    set_irq(4'd4, 4'd0, 1'b1);
    retire(1'b0, 1'b0, '0);
    set_irq(4'd0, 4'd0, 1'b0);
    chk("R9", "squash cleared by trap", {31'b0, squash_slot}, 32'h0);
    chk("R8", "trap_type level 4", {24'b0, trap_type}, 32'h14);
    chk("R8", "trap_pc", trap_pc, 32'h808);
    chk("R8", "trap_npc", trap_npc, 32'h80C);
    give_vector(32'hA00);
    chk("R9", "no squash after vector", {31'b0, squash_slot}, 32'h0);
    retire(1'b0, 1'b0, '0);
    chk("R10", "second vector plus 4", fetch_addr, 32'hA04);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_taken();
    t_annul();
    t_taken_annul();
    t_irq_blocked();
    t_irq_in_slot();
    t_irq_clears_annul();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule